// File: doc/BRIEF.md
# Floating-point exception flag and trap-enable bank

This block keeps the sticky status of the five floating-point exception classes next to their five trap enables. Each cycle an arithmetic unit may present one operation's exception vector. For each raised class, the block does one of two things. If that class's trap is disabled, it records the class in its sticky flag. If the trap is enabled, it sends the class to a one-cycle trap request and leaves the flag unchanged.

Software reaches the flags through a masked write port. A single-bit mask tests or changes one flag. A zero value under a mask clears the selected flags. A full mask restores all five from a saved word, and reading `flags_o` saves all five at once. Hardware never clears a flag. The block also watches the incoming vector for combinations that no single operation can legally raise, and reports them on a protocol-error output.

Top module: `fpx_flag_bank`

## Requirements
- R1: Bit positions in every 5-bit vector are: bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow, bit 4 inexact. While reset is low, the flags, the trap enables, the trap request, the trap cause and the protocol error are all 0, so an exception after reset sets its flag and raises no trap.
- R2: When `exc_valid` is high, every raised class whose trap enable is 0 has its flag set in the next cycle, and that class raises no trap request.
- R3: A set flag stays set in every later cycle until a flag write with that bit in its mask.
- R4: When `exc_valid` is high and any raised class has its trap enable at 1, `trap_req_o` is high for exactly the next cycle. `trap_cause_o` then holds those enabled raised classes, and their flags are left unchanged.
- R5: In one operation, the enabled raised classes go to the trap cause and the disabled raised classes go to the flags, in the same cycle.
- R6: `proto_err_o` is high in the cycle after `exc_valid` is high with more than one class raised, unless the vector is exactly overflow+inexact (5'b10100) or underflow+inexact (5'b11000). Otherwise it is 0. An illegal vector is still applied to the flags and traps.
- R7: A flag write (`flag_we`) loads `flag_val` into the bits set in `flag_mask` and keeps the other bits. If it coincides with an exception, the masked bits take the written value and the unmasked bits still take the hardware set.
- R8: A flag write with mask 5'b11111 restores all five flags from `flag_val` in one cycle, and a mask with value 0 clears the selected flags.
- R9: A trap-enable write (`tren_we`) takes effect at the next clock edge. An exception in the same cycle is routed by the old enables.
- R10: When `exc_valid` is low, `exc_vec` has no effect on flags, trap request or protocol error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_valid | input | 1 | Exception vector of one operation is present |
| exc_vec | input | 5 | Raised exception classes |
| tren_we | input | 1 | Write the trap enables |
| tren_wdata | input | 5 | New trap enables |
| flag_we | input | 1 | Masked flag write |
| flag_mask | input | 5 | Flags affected by the write |
| flag_val | input | 5 | Value written into the masked flags |
| flags_o | output | 5 | Sticky exception flags |
| tren_o | output | 5 | Current trap enables |
| trap_req_o | output | 1 | One-cycle trap request |
| trap_cause_o | output | 5 | Classes that caused the trap request |
| proto_err_o | output | 1 | Illegal exception combination was seen |

## Verification
The hardest cases to reach from the ports are collisions within a single cycle. One is a software flag write landing on the same bit that hardware is setting. The other is a trap-enable change arriving together with an exception that it would re-route. The stimulus table places these in single rows, so both events meet at one edge. The expected results are worked out from the priority and old-enable rules. Illegal combinations are mixed with the two legal pairs so that the error output is seen to assert and to stay low.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int unsigned NEXC  = 5;
  localparam int unsigned B_INV = 0;
  localparam int unsigned B_DZ  = 1;
  localparam int unsigned B_OVF = 2;
  localparam int unsigned B_UNF = 3;
  localparam int unsigned B_INX = 4;

  typedef logic [NEXC-1:0] exc_t;

  localparam exc_t PAIR_OVF_INX = exc_t'((1 << B_OVF) | (1 << B_INX));
  localparam exc_t PAIR_UNF_INX = exc_t'((1 << B_UNF) | (1 << B_INX));

  // Can one operation legally raise this combination of classes?
  function automatic logic combo_legal(exc_t v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < NEXC; i++) n += v[i] ? 1 : 0;
    if (n <= 1) return 1'b1;
    return (v == PAIR_OVF_INX) || (v == PAIR_UNF_INX);
  endfunction

  // Next flag state: hardware sets OR in; masked write bits override.
  function automatic exc_t flag_next(exc_t cur, exc_t hw_set, logic wr,
                                     exc_t mask, exc_t val);
    exc_t merged;
    merged = cur | hw_set;
    if (wr) merged = (merged & ~mask) | (val & mask);
    return merged;
  endfunction
endpackage

// File: rtl/fpx_exc_split.sv
module fpx_exc_split #(
  parameter int unsigned N = fpx_pkg::NEXC
) (
  input  logic         exc_valid,
  input  logic [N-1:0] exc_vec,
  input  logic [N-1:0] tren,
  output logic [N-1:0] set_vec,
  output logic [N-1:0] trap_vec
);
  for (genvar g = 0; g < N; g++) begin : g_cls
    logic hit;
    assign hit         = exc_valid & exc_vec[g];
    assign set_vec[g]  = hit & ~tren[g];
    assign trap_vec[g] = hit &  tren[g];
  end
endmodule

// File: rtl/fpx_flag_store.sv
module fpx_flag_store #(
  parameter int unsigned N = fpx_pkg::NEXC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         wr_en,
  input  logic [N-1:0] wr_mask,
  input  logic [N-1:0] wr_val,
  output logic [N-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= fpx_pkg::flag_next(flags, set_vec, wr_en, wr_mask, wr_val);
  end
endmodule

// File: rtl/fpx_trap_gen.sv
module fpx_trap_gen #(
  parameter int unsigned N = fpx_pkg::NEXC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] trap_vec,
  output logic         trap_req,
  output logic [N-1:0] trap_cause
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_req   <= 1'b0;
      trap_cause <= '0;
    end else begin
      trap_req   <= |trap_vec;
      trap_cause <= trap_vec;
    end
  end
endmodule

// File: rtl/fpx_combo_check.sv
module fpx_combo_check (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_valid,
  input  fpx_pkg::exc_t exc_vec,
  output logic          err
);
  logic bad_now;
  assign bad_now = exc_valid & ~fpx_pkg::combo_legal(exc_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= bad_now;
  end
endmodule

// File: rtl/fpx_flag_bank.sv
module fpx_flag_bank #(
  parameter int unsigned N = fpx_pkg::NEXC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         exc_valid,
  input  logic [N-1:0] exc_vec,
  input  logic         tren_we,
  input  logic [N-1:0] tren_wdata,
  input  logic         flag_we,
  input  logic [N-1:0] flag_mask,
  input  logic [N-1:0] flag_val,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] tren_o,
  output logic         trap_req_o,
  output logic [N-1:0] trap_cause_o,
  output logic         proto_err_o
);
  // Routed events, named for observation.
  logic [N-1:0] set_vec;
  logic [N-1:0] trap_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tren_o <= '0;
    else if (tren_we) tren_o <= tren_wdata;
  end

  fpx_exc_split #(.N(N)) split_i (
    .exc_valid (exc_valid),
    .exc_vec   (exc_vec),
    .tren      (tren_o),
    .set_vec   (set_vec),
    .trap_vec  (trap_vec)
  );

  fpx_flag_store #(.N(N)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .wr_en   (flag_we),
    .wr_mask (flag_mask),
    .wr_val  (flag_val),
    .flags   (flags_o)
  );

  fpx_trap_gen #(.N(N)) trap_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_vec   (trap_vec),
    .trap_req   (trap_req_o),
    .trap_cause (trap_cause_o)
  );

  fpx_combo_check combo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .exc_valid (exc_valid),
    .exc_vec   (exc_vec),
    .err       (proto_err_o)
  );
endmodule

// File: rtl/fpx_flag_bank_chk.sv
module fpx_flag_bank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       exc_valid,
  input logic [4:0] exc_vec,
  input logic       tren_we,
  input logic [4:0] tren_wdata,
  input logic       flag_we,
  input logic [4:0] flag_mask,
  input logic [4:0] flag_val,
  input logic [4:0] flags_o,
  input logic [4:0] tren_o,
  input logic       trap_req_o,
  input logic [4:0] trap_cause_o,
  input logic       proto_err_o
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (flags_o == 5'd0 && tren_o == 5'd0 && !trap_req_o && !proto_err_o));

  // R3: no flag falls unless a write masked it
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flags_o) & ~($past(flag_we) ? $past(flag_mask) : 5'd0) & ~flags_o) == 5'd0));

  // R4: a trapped class never rises in the flags on its own
  p_trap_no_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flag_we) |-> ((flags_o & ~$past(flags_o) & $past(tren_o)) == 5'd0));

  p_cause_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((trap_cause_o & ~$past(tren_o)) == 5'd0));

  // R2: no trap is raised from a cycle without a valid vector
  p_idle_no_trap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |=> !trap_req_o);

  // R6: overflow+inexact is 5'b10100, underflow+inexact is 5'b11000
  p_proto_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && $countones(exc_vec) > 1 && exc_vec != 5'b10100 && exc_vec != 5'b11000)
      |=> proto_err_o);

  p_proto_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |=> !proto_err_o);

  p_write_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> ((flags_o & $past(flag_mask)) == ($past(flag_val) & $past(flag_mask))));

  p_tren_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tren_we |=> (tren_o == $past(tren_wdata)));
endmodule

bind fpx_flag_bank fpx_flag_bank_chk chk_i (.*);

// File: tb/fpx_flag_bank_tb_top.sv
`timescale 1ns/1ps
module fpx_flag_bank_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exc_valid = 1'b0;
  logic [4:0] exc_vec = '0;
  logic       tren_we = 1'b0;
  logic [4:0] tren_wdata = '0;
  logic       flag_we = 1'b0;
  logic [4:0] flag_mask = '0;
  logic [4:0] flag_val = '0;
  logic [4:0] flags_o, tren_o, trap_cause_o;
  logic       trap_req_o, proto_err_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fpx_flag_bank dut_i (.*);

  typedef struct packed {
    logic [3:0] rq;
    logic       ev;  logic [4:0] vec;
    logic       fw;  logic [4:0] msk; logic [4:0] val;
    logic       tw;  logic [4:0] twd;
    logic [4:0] xf;  logic xt; logic [4:0] xc; logic xe;
  } row_t;

  // Bits: 0 invalid, 1 div-zero, 2 overflow, 3 underflow, 4 inexact.
  localparam int NROW = 16;
  localparam row_t TBL [NROW] = '{
    '{4'd2,  1'b1,5'b10100, 1'b0,5'b00000,5'b00000, 1'b0,5'b00000, 5'b10100,1'b0,5'b00000,1'b0}, // R2 ovf+inx
    '{4'd3,  1'b0,5'b00000, 1'b0,5'b00000,5'b00000, 1'b0,5'b00000, 5'b10100,1'b0,5'b00000,1'b0}, // R3 sticky
    '{4'd9,  1'b0,5'b00000, 1'b0,5'b00000,5'b00000, 1'b1,5'b00010, 5'b10100,1'b0,5'b00000,1'b0}, // R9 enable dz
    '{4'd4,  1'b1,5'b00010, 1'b0,5'b00000,5'b00000, 1'b0,5'b00000, 5'b10100,1'b1,5'b00010,1'b0}, // R4 trap dz
    '{4'd4,  1'b0,5'b00000, 1'b0,5'b00000,5'b00000, 1'b0,5'b00000, 5'b10100,1'b0,5'b00000,1'b0}, // R4 pulse ends
    '{4'd9,  1'b1,5'b00010, 1'b0,5'b00000,5'b00000, 1'b1,5'b00100, 5'b10100,1'b1,5'b00010,1'b0}, // R9 old enable used
    '{4'd8,  1'b0,5'b00000, 1'b1,5'b11111,5'b00000, 1'b0,5'b00000, 5'b00000,1'b0,5'b00000,1'b0}, // R8 clear all
    '{4'd5,  1'b1,5'b10100, 1'b0,5'b00000,5'b00000, 1'b0,5'b00000, 5'b10000,1'b1,5'b00100,1'b0}, // R5 split
    '{4'd6,  1'b1,5'b00011, 1'b0,5'b00000,5'b00000, 1'b0,5'b00000, 5'b10011,1'b0,5'b00000,1'b1}, // R6 illegal
    '{4'd10, 1'b0,5'b11111, 1'b0,5'b00000,5'b00000, 1'b0,5'b00000, 5'b10011,1'b0,5'b00000,1'b0}, // R10 ignored
    '{4'd6,  1'b1,5'b11000, 1'b0,5'b00000,5'b00000, 1'b0,5'b00000, 5'b11011,1'b0,5'b00000,1'b0}, // R6 unf+inx legal
    '{4'd7,  1'b1,5'b00010, 1'b1,5'b00010,5'b00000, 1'b0,5'b00000, 5'b11001,1'b0,5'b00000,1'b0}, // R7 write wins
    '{4'd7,  1'b1,5'b00010, 1'b1,5'b00001,5'b00000, 1'b0,5'b00000, 5'b11010,1'b0,5'b00000,1'b0}, // R7 set unmasked
    '{4'd8,  1'b0,5'b00000, 1'b1,5'b11111,5'b01001, 1'b0,5'b00000, 5'b01001,1'b0,5'b00000,1'b0}, // R8 restore
    '{4'd9,  1'b1,5'b00100, 1'b0,5'b00000,5'b00000, 1'b1,5'b00000, 5'b01001,1'b1,5'b00100,1'b0}, // R9 old enable
    '{4'd9,  1'b1,5'b00100, 1'b0,5'b00000,5'b00000, 1'b0,5'b00000, 5'b01101,1'b0,5'b00000,1'b0}  // R9 new enable
  };

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_row(input row_t r, input int idx);
    string t;
    t = $sformatf("R%0d row%0d", r.rq, idx);
    chk({t, " flags"}, flags_o, r.xf);
    chk({t, " trap_req"}, {4'd0, trap_req_o}, {4'd0, r.xt});
    chk({t, " cause"}, trap_cause_o, r.xc);
    chk({t, " proto_err"}, {4'd0, proto_err_o}, {4'd0, r.xe});
  endtask

  task automatic drive_idle();
    exc_valid = 1'b0; exc_vec = '0; flag_we = 1'b0; flag_mask = '0;
    flag_val = '0; tren_we = 1'b0; tren_wdata = '0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset flags", flags_o, 5'd0);
    chk("R1 reset tren", tren_o, 5'd0);
    chk("R1 reset trap", {trap_req_o, trap_cause_o[3:0]}, 5'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NROW; i++) begin
      @(negedge clk);
      if (i > 0) check_row(TBL[i-1], i-1);
      exc_valid = TBL[i].ev;  exc_vec = TBL[i].vec;
      flag_we = TBL[i].fw;    flag_mask = TBL[i].msk; flag_val = TBL[i].val;
      tren_we = TBL[i].tw;    tren_wdata = TBL[i].twd;
    end
    @(negedge clk);
    check_row(TBL[NROW-1], NROW-1);
    drive_idle();
    chk("R9 tren after write", tren_o, 5'd0);

    // R1 mid-run reset, then default is no trapping
    exc_valid = 1'b1; exc_vec = 5'b00100; tren_we = 1'b1; tren_wdata = 5'b11111;
    @(negedge clk);
    drive_idle();
    rst_n = 1'b0;
    #1;
    chk("R1 async reset flags", flags_o, 5'd0);
    chk("R1 async reset tren", tren_o, 5'd0);
    @(negedge clk);
    rst_n = 1'b1;
    exc_valid = 1'b1; exc_vec = 5'b00001;
    @(negedge clk);
    drive_idle();
    chk("R1 default sets flag", flags_o, 5'b00001);
    chk("R1 default no trap", {4'd0, trap_req_o}, 5'd0);

    // R10 valid low with a full vector, while a trap is enabled
    tren_we = 1'b1; tren_wdata = 5'b00010;
    @(negedge clk);
    drive_idle();
    exc_vec = 5'b11111;
    @(negedge clk);
    drive_idle();
    chk("R10 flags untouched", flags_o, 5'b00001);
    chk("R10 no trap", {4'd0, trap_req_o}, 5'd0);
    chk("R10 no proto err", {4'd0, proto_err_o}, 5'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule